// File: doc/BRIEF.md
# Socket Memory and I/O Window Decoder

This block sits between a latched ISA-side address and one card socket. For a memory cycle it compares the system page (address bits 23:12) with five programmable memory windows. When one of them matches, it relocates the page into the 64 MB card space by adding that window's 14-bit offset. For an I/O cycle it compares the full 16-bit port address with two I/O windows and passes the address through. Each hit also produces the side information the card bus sequencer needs: the attribute/common memory select, a write-suppress flag, the cycle length in bus clocks, a no-wait-state request and the data width.

Window settings arrive as flat vectors from a register file that lives outside the block. Each window field is packed at its window index times the field width. The decode is purely combinational. Its result is captured into the output registers on every clock edge where `cyc_valid` is high. While `cyc_valid` is low, the outputs hold their last captured value.

Top module: `socket_window_decoder`

## Requirements
- R1: A memory cycle hits memory window w only when `mw_en[w]` is 1 and `sys_addr[23:12]` lies between that window's 12-bit start and stop values, with both bounds included.
- R2: A memory cycle whose address has bits 23:16 all zero (below 64 KB) is a miss, whatever the window settings are.
- R3: When several windows of the selected kind match, `hit_win` reports the lowest-numbered one, and all other outputs are taken from that window.
- R4: On a memory hit, `card_addr[25:12]` equals `sys_addr[23:12]` plus the window's 14-bit offset, modulo 2^14. `card_addr[11:0]` equals `sys_addr[11:0]`.
- R5: An I/O cycle hits I/O window w only when `iw_en[w]` is 1, `aen` is 0, and `sys_addr[15:0]` lies inclusively between that window's 16-bit start and stop. On an I/O hit, `card_addr` equals `sys_addr[15:0]` zero-extended.
- R6: `cyc_io` = 1 checks only the I/O windows and `cyc_io` = 0 checks only the memory windows. Every miss drives `hit`, `hit_win`, `card_addr`, `wr_inhibit`, `bus_clks`, `nows` and `wide16` to 0.
- R7: `reg_n` is 0 only on a memory hit through a window whose attribute bit is 1. In all other cases it is 1.
- R8: `wr_inhibit` is 1 only on a memory write (`cyc_write` = 1) that hits a window whose write-protect bit is 1. Reads through that window are not inhibited.
- R9: `bus_clks` is 3 plus the window's 2-bit wait code (00 to 11 gives 3 to 6) on a memory hit, 3 on an I/O hit, and 0 on a miss.
- R10: On a memory hit, `nows` equals the window's zero-wait bit AND `card_wait_n`. It is 0 on an I/O hit or a miss.
- R11: `wide16` on a memory hit is the window's size bit. On an I/O hit it is `card_iois16` when the window's source bit is 1, and the window's size bit otherwise.
- R12: After a synchronous reset all outputs are 0 except `reg_n`, which is 1. Outputs change only one clock after an edge where `cyc_valid` = 1, and they hold while `cyc_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | Capture the decode of the current cycle |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_write | input | 1 | 1 = write cycle |
| aen | input | 1 | DMA address enable; 1 during DMA cycles |
| sys_addr | input | 24 | Latched system address |
| card_wait_n | input | 1 | Card wait request, active low |
| card_iois16 | input | 1 | Card reports a 16-bit I/O port |
| mw_en | input | 5 | Memory window enables |
| mw_start | input | 60 | Memory window start pages, 12 bits each |
| mw_stop | input | 60 | Memory window stop pages, 12 bits each |
| mw_offset | input | 70 | Memory window card offsets, 14 bits each |
| mw_wp | input | 5 | Memory window write protect |
| mw_attr | input | 5 | Memory window attribute-space select |
| mw_wait | input | 10 | Memory window wait codes, 2 bits each |
| mw_zero_ws | input | 5 | Memory window zero-wait request |
| mw_wide | input | 5 | Memory window 16-bit data size |
| iw_en | input | 2 | I/O window enables |
| iw_start | input | 32 | I/O window start addresses, 16 bits each |
| iw_stop | input | 32 | I/O window stop addresses, 16 bits each |
| iw_wide | input | 2 | I/O window 16-bit data size |
| iw_use_iois | input | 2 | I/O window takes its width from `card_iois16` |
| hit | output | 1 | A window matched |
| hit_win | output | 3 | Index of the matching window |
| card_addr | output | 26 | Translated card address |
| reg_n | output | 1 | Attribute memory select, active low |
| wr_inhibit | output | 1 | Suppress the write strobe |
| bus_clks | output | 3 | Cycle length in bus clocks |
| nows | output | 1 | Request no-wait-state termination |
| wide16 | output | 1 | 16-bit data path |

## Verification
Every result is due exactly one rising edge after the edge at which `cyc_valid` is sampled high, because there is a single register stage. The bench drives inputs on the falling edge. It predicts the registered value with a behavioural model at the moment of the rising edge and compares all eight outputs at the following falling edge. Idle cycles carry the previous prediction forward, so the hold behaviour is checked on every clock. Directed cycles placed on window bounds, offset wrap, overlaps, DMA and the low 64 KB are then followed by address patterns aimed around the window edges.

// File: rtl/swd_pkg.sv
// Shared sizing constants for the socket window decoder.
// Assumes a 24-bit system bus, a 26-bit card space and 4 KB pages.
package swd_pkg;
    localparam int NUM_MEM_WIN  = 5;
    localparam int NUM_IO_WIN   = 2;
    localparam int SYS_AW       = 24;
    localparam int CARD_AW      = 26;
    localparam int PAGE_LSB     = 12;
    localparam int IO_AW        = 16;
    localparam int LOW_LSB      = 16;
    localparam int WAIT_W       = 2;
    localparam int BASE_CLKS    = 3;
endpackage

// File: rtl/swd_mem_win.sv
// One memory window comparator with page relocation.
// Assumes start/stop are page numbers; both bounds inclusive; offset wraps.
module swd_mem_win #(
    parameter int PG_W  = 12,
    parameter int OFS_W = 14
) (
    input  logic [PG_W-1:0]  page,
    input  logic             en,
    input  logic [PG_W-1:0]  start_pg,
    input  logic [PG_W-1:0]  stop_pg,
    input  logic [OFS_W-1:0] offset,
    output logic             match,
    output logic [OFS_W-1:0] card_page
);
    // Range compare and relocation sum for this window.
    always_comb begin
        match     = en && (page >= start_pg) && (page <= stop_pg);
        card_page = OFS_W'(page) + offset;
    end
endmodule

// File: rtl/swd_io_win.sv
// One I/O window comparator over the full port address.
// Assumes the caller gates DMA cycles; bounds inclusive.
module swd_io_win #(
    parameter int IO_AW = 16
) (
    input  logic [IO_AW-1:0] port,
    input  logic             en,
    input  logic [IO_AW-1:0] start_a,
    input  logic [IO_AW-1:0] stop_a,
    output logic             match
);
    // Inclusive range compare.
    always_comb match = en && (port >= start_a) && (port <= stop_a);
endmodule

// File: rtl/swd_pick.sv
// Lowest-index-wins selector over a request vector.
// Assumes idx is only meaningful while any is high.
module swd_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set request is the last assignment.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/socket_window_decoder.sv
// Decodes one socket's memory and I/O windows and registers the result.
// Assumes sys_addr and cycle qualifiers are stable around the capturing edge
// and that window settings come from an external register file.
module socket_window_decoder
    import swd_pkg::*;
#(
    parameter int NMW  = NUM_MEM_WIN,
    parameter int NIW  = NUM_IO_WIN,
    parameter int SAW  = SYS_AW,
    parameter int CAW  = CARD_AW,
    parameter int PLSB = PAGE_LSB,
    parameter int IAW  = IO_AW,
    parameter int LLSB = LOW_LSB,
    parameter int WSW  = WAIT_W,
    parameter int BCLK = BASE_CLKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cyc_valid,
    input  logic                 cyc_io,
    input  logic                 cyc_write,
    input  logic                 aen,
    input  logic [SAW-1:0]       sys_addr,
    input  logic                 card_wait_n,
    input  logic                 card_iois16,
    input  logic [NMW-1:0]       mw_en,
    input  logic [NMW*(SAW-PLSB)-1:0] mw_start,
    input  logic [NMW*(SAW-PLSB)-1:0] mw_stop,
    input  logic [NMW*(CAW-PLSB)-1:0] mw_offset,
    input  logic [NMW-1:0]       mw_wp,
    input  logic [NMW-1:0]       mw_attr,
    input  logic [NMW*WSW-1:0]   mw_wait,
    input  logic [NMW-1:0]       mw_zero_ws,
    input  logic [NMW-1:0]       mw_wide,
    input  logic [NIW-1:0]       iw_en,
    input  logic [NIW*IAW-1:0]   iw_start,
    input  logic [NIW*IAW-1:0]   iw_stop,
    input  logic [NIW-1:0]       iw_wide,
    input  logic [NIW-1:0]       iw_use_iois,
    output logic                 hit,
    output logic [$clog2(NMW > NIW ? NMW : NIW)-1:0] hit_win,
    output logic [CAW-1:0]       card_addr,
    output logic                 reg_n,
    output logic                 wr_inhibit,
    output logic [$clog2(BCLK + (1 << WSW))-1:0] bus_clks,
    output logic                 nows,
    output logic                 wide16
);
    localparam int PG_W  = SAW - PLSB;
    localparam int OFS_W = CAW - PLSB;
    localparam int IDX_W = $clog2(NMW > NIW ? NMW : NIW);
    localparam int CLK_W = $clog2(BCLK + (1 << WSW));

    logic [PG_W-1:0]  page;
    logic [NMW-1:0]   mw_match;
    logic [OFS_W-1:0] mw_cpage [NMW];
    logic [NIW-1:0]   iw_match;
    logic             mem_ok, io_ok;
    logic [NMW-1:0]   mw_req;
    logic [NIW-1:0]   iw_req;
    logic             m_any, i_any;
    logic [IDX_W-1:0] m_idx, i_idx;

    assign page = sys_addr[SAW-1:PLSB];

    genvar g;
    generate
        for (g = 0; g < NMW; g++) begin : g_mw
            swd_mem_win #(.PG_W(PG_W), .OFS_W(OFS_W)) u_win (
                .page      (page),
                .en        (mw_en[g]),
                .start_pg  (mw_start[g*PG_W +: PG_W]),
                .stop_pg   (mw_stop[g*PG_W +: PG_W]),
                .offset    (mw_offset[g*OFS_W +: OFS_W]),
                .match     (mw_match[g]),
                .card_page (mw_cpage[g])
            );
        end
        for (g = 0; g < NIW; g++) begin : g_iw
            swd_io_win #(.IO_AW(IAW)) u_win (
                .port    (sys_addr[IAW-1:0]),
                .en      (iw_en[g]),
                .start_a (iw_start[g*IAW +: IAW]),
                .stop_a  (iw_stop[g*IAW +: IAW]),
                .match   (iw_match[g])
            );
        end
    endgenerate

    // Qualify matches by cycle type, the low-64K hole and DMA.
    always_comb begin
        mem_ok = !cyc_io && (|sys_addr[SAW-1:LLSB]);
        io_ok  = cyc_io && !aen;
        mw_req = mw_match & {NMW{mem_ok}};
        iw_req = iw_match & {NIW{io_ok}};
    end

    swd_pick #(.N(NMW), .IW(IDX_W)) u_mpick (.req(mw_req), .any(m_any), .idx(m_idx));
    swd_pick #(.N(NIW), .IW(IDX_W)) u_ipick (.req(iw_req), .any(i_any), .idx(i_idx));

    logic             n_hit, n_reg_n, n_wrinh, n_nows, n_wide;
    logic [IDX_W-1:0] n_win;
    logic [CAW-1:0]   n_addr;
    logic [CLK_W-1:0] n_clks;

    // Build the next output set from the winning window.
    always_comb begin
        n_hit   = 1'b0;
        n_win   = '0;
        n_addr  = '0;
        n_reg_n = 1'b1;
        n_wrinh = 1'b0;
        n_clks  = '0;
        n_nows  = 1'b0;
        n_wide  = 1'b0;
        if (m_any) begin
            n_hit   = 1'b1;
            n_win   = m_idx;
            n_addr  = {mw_cpage[m_idx], sys_addr[PLSB-1:0]};
            n_reg_n = !mw_attr[m_idx];
            n_wrinh = cyc_write && mw_wp[m_idx];
            n_clks  = CLK_W'(BCLK) + CLK_W'(mw_wait[m_idx*WSW +: WSW]);
            n_nows  = mw_zero_ws[m_idx] && card_wait_n;
            n_wide  = mw_wide[m_idx];
        end else if (i_any) begin
            n_hit   = 1'b1;
            n_win   = i_idx;
            n_addr  = CAW'(sys_addr[IAW-1:0]);
            n_clks  = CLK_W'(BCLK);
            n_wide  = iw_use_iois[i_idx] ? card_iois16 : iw_wide[i_idx];
        end
    end

    // Capture the decode once per qualified bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit        <= 1'b0;
            hit_win    <= '0;
            card_addr  <= '0;
            reg_n      <= 1'b1;
            wr_inhibit <= 1'b0;
            bus_clks   <= '0;
            nows       <= 1'b0;
            wide16     <= 1'b0;
        end else if (cyc_valid) begin
            hit        <= n_hit;
            hit_win    <= n_win;
            card_addr  <= n_addr;
            reg_n      <= n_reg_n;
            wr_inhibit <= n_wrinh;
            bus_clks   <= n_clks;
            nows       <= n_nows;
            wide16     <= n_wide;
        end
    end
endmodule

// File: rtl/swd_checker.sv
// Port-level temporal checks for socket_window_decoder.
// Assumes one register stage between a qualified cycle and its result.
module swd_checker #(
    parameter int SAW  = 24,
    parameter int LLSB = 16,
    parameter int CLKW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cyc_valid,
    input logic            cyc_io,
    input logic            cyc_write,
    input logic            aen,
    input logic [SAW-1:0]  sys_addr,
    input logic            hit,
    input logic            reg_n,
    input logic            wr_inhibit,
    input logic [CLKW-1:0] bus_clks,
    input logic            nows
);
    AST_LOW_PAGE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_io && sys_addr[SAW-1:LLSB] == '0) |=> !hit); // R2
    AST_DMA_IO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_io && aen) |=> !hit); // R5
    AST_IO_NO_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_io) |=> (reg_n && !wr_inhibit && !nows)); // R7
    AST_READ_NO_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_write) |=> !wr_inhibit); // R8
    AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> (hit ? (bus_clks >= CLKW'(3) && bus_clks <= CLKW'(6)) : (bus_clks == '0))); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> ($stable(hit) && $stable(bus_clks) && $stable(reg_n))); // R12
endmodule

bind socket_window_decoder swd_checker #(.SAW(SAW), .LLSB(LLSB), .CLKW(CLK_W)) i_swd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_valid  (cyc_valid),
    .cyc_io     (cyc_io),
    .cyc_write  (cyc_write),
    .aen        (aen),
    .sys_addr   (sys_addr),
    .hit        (hit),
    .reg_n      (reg_n),
    .wr_inhibit (wr_inhibit),
    .bus_clks   (bus_clks),
    .nows       (nows)
);

// File: tb/test_socket_window_decoder.sv
// Self-checking bench: behavioural model compared on every clock.
module test_socket_window_decoder;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0, cyc_valid = 1'b0, cyc_io = 1'b0, cyc_write = 1'b0, aen = 1'b0;
    logic [23:0] sys_addr = '0;
    logic        card_wait_n = 1'b1, card_iois16 = 1'b0;
    logic [4:0]  mw_en = '0, mw_wp = '0, mw_attr = '0, mw_zero_ws = '0, mw_wide = '0;
    logic [59:0] mw_start = '0, mw_stop = '0;
    logic [69:0] mw_offset = '0;
    logic [9:0]  mw_wait = '0;
    logic [1:0]  iw_en = '0, iw_wide = '0, iw_use_iois = '0;
    logic [31:0] iw_start = '0, iw_stop = '0;
    logic        hit, reg_n, wr_inhibit, nows, wide16;
    logic [2:0]  hit_win, bus_clks;
    logic [25:0] card_addr;

    socket_window_decoder i_socket_window_decoder (.*);

    int n_checks = 0, n_fail = 0;
    // expected (registered) and pending (model of current inputs)
    int e_hit, e_win, e_addr, e_reg, e_inh, e_clk, e_nows, e_wide;
    int p_hit, p_win, p_addr, p_reg, p_inh, p_clk, p_nows, p_wide;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model of the decode for the present inputs.
    task automatic model();
        int page;
        page = int'(sys_addr) >> 12;
        p_hit = 0; p_win = 0; p_addr = 0; p_reg = 1; p_inh = 0; p_clk = 0; p_nows = 0; p_wide = 0;
        if (!cyc_io) begin
            if (int'(sys_addr) >= 65536) begin
                for (int w = 4; w >= 0; w--) begin
                    if (mw_en[w] && page >= int'(mw_start[w*12 +: 12]) && page <= int'(mw_stop[w*12 +: 12])) begin
                        p_hit = 1; p_win = w;
                    end
                end
                if (p_hit == 1) begin
                    p_addr = (((page + int'(mw_offset[p_win*14 +: 14])) % 16384) * 4096) + (int'(sys_addr) % 4096);
                    p_reg  = mw_attr[p_win] ? 0 : 1;
                    p_inh  = (cyc_write && mw_wp[p_win]) ? 1 : 0;
                    p_clk  = 3 + int'(mw_wait[p_win*2 +: 2]);
                    p_nows = (mw_zero_ws[p_win] && card_wait_n) ? 1 : 0;
                    p_wide = int'(mw_wide[p_win]);
                end
            end
        end else if (!aen) begin
            for (int w = 1; w >= 0; w--) begin
                if (iw_en[w] && int'(sys_addr[15:0]) >= int'(iw_start[w*16 +: 16]) &&
                    int'(sys_addr[15:0]) <= int'(iw_stop[w*16 +: 16])) begin
                    p_hit = 1; p_win = w;
                end
            end
            if (p_hit == 1) begin
                p_addr = int'(sys_addr[15:0]);
                p_clk  = 3;
                p_wide = iw_use_iois[p_win] ? int'(card_iois16) : int'(iw_wide[p_win]);
            end
        end
    endtask

    // One clock: predict, let the edge pass, compare at the falling edge.
    task automatic step();
        model();
        @(posedge clk);
        if (!rst_n) begin
            e_hit = 0; e_win = 0; e_addr = 0; e_reg = 1; e_inh = 0; e_clk = 0; e_nows = 0; e_wide = 0;
        end else if (cyc_valid) begin
            e_hit = p_hit; e_win = p_win; e_addr = p_addr; e_reg = p_reg;
            e_inh = p_inh; e_clk = p_clk; e_nows = p_nows; e_wide = p_wide;
        end
        @(negedge clk);
        chk("R1", "hit", int'(hit), e_hit);
        chk("R3", "hit_win", int'(hit_win), e_win);
        chk("R4", "card_addr", int'(card_addr), e_addr);
        chk("R7", "reg_n", int'(reg_n), e_reg);
        chk("R8", "wr_inhibit", int'(wr_inhibit), e_inh);
        chk("R9", "bus_clks", int'(bus_clks), e_clk);
        chk("R10", "nows", int'(nows), e_nows);
        chk("R11", "wide16", int'(wide16), e_wide);
    endtask

    task automatic mem(input logic [23:0] a, input logic wr);
        cyc_valid = 1'b1; cyc_io = 1'b0; cyc_write = wr; aen = 1'b0; sys_addr = a;
        step();
    endtask

    task automatic io(input logic [23:0] a, input logic dma);
        cyc_valid = 1'b1; cyc_io = 1'b1; cyc_write = 1'b0; aen = dma; sys_addr = a;
        step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        repeat (3) step();
        chk("R12", "reset hit", int'(hit), 0);
        chk("R12", "reset reg_n", int'(reg_n), 1);
        chk("R12", "reset bus_clks", int'(bus_clks), 0);
        rst_n = 1'b1;
        // window setup
        mw_en = 5'b11011;
        mw_start[0*12 +: 12] = 12'h010; mw_stop[0*12 +: 12] = 12'h01F; mw_offset[0*14 +: 14] = 14'h0100;
        mw_start[1*12 +: 12] = 12'h018; mw_stop[1*12 +: 12] = 12'h030; mw_offset[1*14 +: 14] = 14'h3FF0;
        mw_start[2*12 +: 12] = 12'h000; mw_stop[2*12 +: 12] = 12'hFFF;
        mw_start[3*12 +: 12] = 12'h000; mw_stop[3*12 +: 12] = 12'h0FF; mw_offset[3*14 +: 14] = 14'h0001;
        mw_start[4*12 +: 12] = 12'h100; mw_stop[4*12 +: 12] = 12'h1FF;
        mw_attr = 5'b00010; mw_wp = 5'b00010; mw_wait = 10'b00_11_00_10_00;
        mw_zero_ws = 5'b00010; mw_wide = 5'b10000;
        iw_en = 2'b11;
        iw_start[15:0] = 16'h0300; iw_stop[15:0] = 16'h031F;
        iw_start[31:16] = 16'h0310; iw_stop[31:16] = 16'h03FF;
        iw_wide = 2'b01; iw_use_iois = 2'b10;

        mem(24'h010000, 1'b0);
        chk("R1", "lower bound hit win0", int'(hit_win), 0);
        chk("R4", "win0 relocated", int'(card_addr), 26'h110000);
        mem(24'h01FABC, 1'b0);
        chk("R4", "upper bound relocated", int'(card_addr), 26'h11FABC);
        mem(24'h018000, 1'b0);
        chk("R3", "overlap lowest wins", int'(hit_win), 0);
        card_wait_n = 1'b1;
        mem(24'h020123, 1'b1);
        chk("R4", "offset wraps", int'(card_addr), 26'h010123);
        chk("R7", "attribute select", int'(reg_n), 0);
        chk("R8", "write inhibited", int'(wr_inhibit), 1);
        chk("R9", "wait code 2", int'(bus_clks), 5);
        chk("R10", "zero wait granted", int'(nows), 1);
        card_wait_n = 1'b0;
        mem(24'h020123, 1'b0);
        chk("R8", "read not inhibited", int'(wr_inhibit), 0);
        chk("R10", "card wait overrides", int'(nows), 0);
        card_wait_n = 1'b1;
        mem(24'h00F000, 1'b0);
        chk("R2", "below 64K miss", int'(hit), 0);
        mem(24'h031000, 1'b0);
        chk("R1", "past stop falls to win3", int'(hit_win), 3);
        chk("R9", "wait code 3", int'(bus_clks), 6);
        mem(24'h100000, 1'b0);
        chk("R11", "memory 16-bit size", int'(wide16), 1);
        mem(24'h200000, 1'b0);
        chk("R6", "miss clears", int'(card_addr), 0);

        io(24'h000300, 1'b0);
        chk("R5", "io start bound", int'(hit), 1);
        chk("R5", "io address", int'(card_addr), 26'h000300);
        io(24'h000300, 1'b1);
        chk("R5", "dma rejected", int'(hit), 0);
        io(24'h000315, 1'b0);
        chk("R3", "io overlap lowest", int'(hit_win), 0);
        card_iois16 = 1'b1;
        io(24'h000320, 1'b0);
        chk("R11", "io width from card", int'(wide16), 1);
        card_iois16 = 1'b0;
        io(24'h000320, 1'b0);
        chk("R11", "io width from card low", int'(wide16), 0);
        io(24'h010310, 1'b0);
        chk("R6", "io cycle ignores memory windows", int'(card_addr), 26'h000310);
        mem(24'h010310, 1'b0);
        chk("R6", "memory cycle ignores io windows", int'(card_addr), 26'h110310);
        cyc_valid = 1'b0; sys_addr = 24'h200000;
        step();
        chk("R12", "hold while idle", int'(card_addr), 26'h110310);

        for (int n = 0; n < 3000; n++) begin
            logic [23:0] a;
            a = $urandom();
            case ($urandom_range(0, 3))
                0: a[23:12] = 12'h010 + 12'($urandom_range(0, 40));
                1: a[23:16] = 8'h00;
                2: a = {8'($urandom()), 16'h0300 + 16'($urandom_range(0, 260))};
                default: ;
            endcase
            cyc_valid = ($urandom_range(0, 5) != 0);
            cyc_io = $urandom(); cyc_write = $urandom(); aen = ($urandom_range(0, 3) == 0);
            card_wait_n = $urandom(); card_iois16 = $urandom();
            sys_addr = a;
            if (n % 500 == 0) begin
                mw_en = $urandom(); mw_attr = $urandom(); mw_wp = $urandom();
                mw_wait = $urandom(); mw_zero_ws = $urandom(); mw_wide = $urandom();
                iw_en = $urandom(); iw_wide = $urandom(); iw_use_iois = $urandom();
            end
            step();
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule